// File: doc/BRIEF.md
# Real-Time Clock Register and Interrupt Unit

This block is the software-facing front of a real-time clock. A processor reaches a 128-byte register space through a two-location port. A write to location 0 picks which byte is addressed. Reads and writes at location 1 then act on that byte. Four of the bytes are control and status registers. The other bytes are plain storage, which the calendar logic and software share.

The calendar counter and the alarm comparator sit in neighbouring blocks. They report to this unit with single-cycle strobes:
- update-cycle start
- update-cycle end
- alarm match

The unit also divides a one-cycle 32768 Hz tick enable down to a programmable periodic event. It records all three event kinds as flags, masks them with enable bits and drives one active-high interrupt level. Software acknowledges the interrupt by reading the flag register, which clears it.

Control register layout:

| Register | Index | Bit 7 | Bit 6 | Bit 5 | Bit 4 | Bit 3 | Lower bits |
|---|---|---|---|---|---|---|---|
| A | 0x0A | update-in-progress | divider [6:4] | divider | divider | rate [3:0] | rate |
| B | 0x0B | SET | periodic enable | alarm enable | update enable | square-wave enable | bits 2:0 are stored only |
| C | 0x0C | master interrupt flag | periodic flag | alarm flag | update flag | 0 | 0 |
| D | 0x0D | reads as 0x80 | | | | | |

Top module: `rtc_regs`

## Requirements
- R1: A write with `sel`=0 stores `wr_data[6:0]` as the index. A read with `sel`=0 returns 0xFF.
- R2: Each index other than 0x0A to 0x0D reads back the last byte written to it. Index 0x37 reaches the same byte as index 0x32, for both reads and writes.
- R3: Writes to C (0x0C) and D (0x0D) are ignored, and D always reads 0x80. Writes to A change bits 6:0 only. The update-in-progress bit (A bit 7) keeps its value.
- R4: A read of C returns its current value. At the next clock, C becomes 0 and `irq` falls. An event flag that arrives in the same cycle as the read is kept.
- R5: An event sets its flag in C: update-end sets bit 4, alarm sets bit 5, periodic sets bit 6. If the matching enable in B (bit 4, 5 or 6) is 1, bit 7 of C is also set. `irq` always follows C bit 7.
- R6: A write to B sets C bit 7 at once if any flag in C[6:4] is pending with its new enable set. Otherwise the write clears C bit 7.
- R7: Writing B with bit 7 (SET) at 1 stores B bit 4 as 0 and clears A bit 7.
- R8: `rst_n` low gives A=0x26, B=0x02, C=0x00 and index 0. A `dev_rst` pulse clears B bits 6, 5 and 3 and all of C.
- R9: The periodic flag is set once per period. The period is counted in `tick_32k` pulses and chosen by A[3:0]: code 1 gives 128 pulses, code 2 gives 64, and codes 3 to 15 give 2^(code-1).
- R10: Rate code 0, or B bit 6 at 0, stops the periodic events. It also restarts the period count from zero.
- R11: While A[6:4]=0b110, update-end, alarm and periodic events set no flag. Writing A with that divider value clears A bit 7.
- R12: `upd_start` sets A bit 7 only when the clock is running: B bit 7 is 0 and A[6:4] is 0b010 or lower. `upd_end` clears A bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous power-on reset |
| dev_rst | input | 1 | Synchronous device reset pulse |
| sel | input | 1 | Port location: 0 = index, 1 = data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects applied at the clock edge) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for the current `sel` and index |
| tick_32k | input | 1 | One-cycle enable at 32768 Hz |
| upd_start | input | 1 | Update-cycle start strobe from the calendar |
| upd_end | input | 1 | Update-cycle end strobe from the calendar |
| alarm_hit | input | 1 | Alarm match strobe |
| irq | output | 1 | Active-high interrupt level |

## Verification
The hardest case to reach is the slow end of the periodic divider. Checking the 128-pulse period needs a long run of ticks with the enable held, and no read of C in between. The stimulus streams consecutive ticks and samples `irq` exactly after pulse 127 and after pulse 128.

Register-B re-evaluation with a stale flag is also hard to reach. To get there, the bench raises the alarm flag while its enable is off, then turns the enable on with a plain register write. A behavioural model runs alongside and checks `irq` and every read on every clock.

// File: rtl/rtl_rtc_regs.sv
module rtc_regs #(
  parameter int DEPTH     = 128,
  parameter int ALIAS_IDX = 'h37,
  parameter int CENT_IDX  = 'h32,
  parameter int PER_W     = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dev_rst,
  input  logic       sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       tick_32k,
  input  logic       upd_start,
  input  logic       upd_end,
  input  logic       alarm_hit,
  output logic       irq
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [IW-1:0] IX_A = IW'('h0A);
  localparam logic [IW-1:0] IX_B = IW'('h0B);
  localparam logic [IW-1:0] IX_C = IW'('h0C);
  localparam logic [IW-1:0] IX_D = IW'('h0D);
  localparam logic [7:0] D_VAL = 8'h80;

  logic [IW-1:0] idx, eff;
  logic [7:0] reg_a, reg_b, reg_c;
  logic [7:0] mem [DEPTH];
  logic [PER_W-1:0] pcnt, period;

  function automatic logic [PER_W-1:0] per_len(input logic [3:0] code);
    if (code == 4'd0) return '0;
    if (code == 4'd1) return PER_W'(128);
    if (code == 4'd2) return PER_W'(64);
    return PER_W'(1) << (code - 4'd1);
  endfunction

  assign eff = (idx == IW'(ALIAS_IDX)) ? IW'(CENT_IDX) : idx;

  logic data_wr, a_wr, b_wr, rd_c, div_rst, running, per_on, per_hit;
  assign data_wr = wr_en & sel;
  assign a_wr    = data_wr & (eff == IX_A);
  assign b_wr    = data_wr & (eff == IX_B);
  assign rd_c    = rd_en & sel & (eff == IX_C);
  assign div_rst = reg_a[6:4] == 3'b110;
  assign running = !reg_b[7] && (reg_a[6:4] <= 3'b010);
  assign period  = per_len(reg_a[3:0]);
  assign per_on  = (period != '0) && reg_b[6] && !div_rst;
  assign per_hit = per_on && tick_32k && ({1'b0, pcnt} + 1'b1 >= {1'b0, period});

  logic [2:0] ev, c_base, c_flags;
  logic [7:0] b_new;
  logic irqf_n, uip_n;
  assign ev      = {per_hit, alarm_hit & !div_rst, upd_end & !div_rst};
  assign c_base  = rd_c ? 3'b000 : reg_c[6:4];
  assign c_flags = c_base | ev;
  assign b_new   = wr_data[7] ? (wr_data & 8'hEF) : wr_data;

  always_comb begin
    if (b_wr) irqf_n = |(b_new[6:4] & c_flags);
    else      irqf_n = (reg_c[7] & !rd_c) | (|(ev & ~c_base & reg_b[6:4]));
    uip_n = reg_a[7];
    if (upd_start && running) uip_n = 1'b1;
    if (upd_end || (b_wr && wr_data[7]) || (a_wr && wr_data[6:4] == 3'b110)) uip_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      reg_a <= 8'h26;
      reg_b <= 8'h02;
      reg_c <= 8'h00;
      pcnt  <= '0;
    end else begin
      if (wr_en && !sel) idx <= wr_data[IW-1:0];
      reg_a <= {uip_n, a_wr ? wr_data[6:0] : reg_a[6:0]};
      if (dev_rst) begin
        reg_b <= reg_b & 8'h97;
        reg_c <= 8'h00;
      end else begin
        if (b_wr) reg_b <= b_new;
        reg_c <= {irqf_n, c_flags, 4'h0};
      end
      if (!per_on)       pcnt <= '0;
      else if (per_hit)  pcnt <= '0;
      else if (tick_32k) pcnt <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (data_wr && eff != IX_A && eff != IX_B && eff != IX_C && eff != IX_D) mem[eff] <= wr_data;

  always_comb begin
    if (!sel) rd_data = 8'hFF;
    else case (eff)
      IX_A:    rd_data = reg_a;
      IX_B:    rd_data = reg_b;
      IX_C:    rd_data = reg_c;
      IX_D:    rd_data = D_VAL;
      default: rd_data = mem[eff];
    endcase
  end

  assign irq = reg_c[7];

  p_irq_drop_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && ev == 3'b000 && !b_wr) |=> !irq);
  p_enabled_update_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_end && !div_rst && reg_b[4] && !dev_rst && !b_wr) |=> irq);
  p_set_strips_uie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (b_wr && wr_data[7] && !dev_rst) |=> (!reg_b[4] && !reg_a[7]));
  p_c_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && eff == IX_C && ev == 3'b000 && !dev_rst && !rd_en) |=> $stable(reg_c));
  p_div_reset_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    div_rst |=> ((reg_c[6:4] & ~$past(reg_c[6:4])) == 3'b000));
  p_uip_needs_running_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_a[7]) |-> $past(running));
endmodule

// File: tb/tb_rtc_regs.sv
module rtc_regs_tb;
  logic clk = 1'b0, rst_n = 1'b0, dev_rst = 1'b0, sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic tick_32k = 1'b0, upd_start = 1'b0, upd_end = 1'b0, alarm_hit = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic irq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  rtc_regs u_dut (.clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .sel(sel), .wr_en(wr_en),
    .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data), .tick_32k(tick_32k),
    .upd_start(upd_start), .upd_end(upd_end), .alarm_hit(alarm_hit), .irq(irq));

  // behavioural reference model
  int mA, mB, mC, mIdx, mP;
  int mMem [128];

  function automatic int per_of(int code);
    if (code == 0) return 0;
    if (code == 1) return 128;
    if (code == 2) return 64;
    return 1 << (code - 1);
  endfunction

  function automatic int m_eff();
    return (mIdx == 'h37) ? 'h32 : mIdx;
  endfunction

  function automatic int m_read();
    int e = m_eff();
    if (!sel) return 'hFF;
    if (e == 'h0A) return mA;
    if (e == 'h0B) return mB;
    if (e == 'h0C) return mC;
    if (e == 'h0D) return 'h80;
    return mMem[e];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mA = 'h26; mB = 'h02; mC = 0; mIdx = 0; mP = 0;
    end else begin
      int e, dv, per, evs, base, nb, uip, nf, irqf;
      bit run, drst, pon, hit, rdc, bw, aw;
      e = m_eff();
      dv = (mA >> 4) & 7;
      drst = (dv == 6);
      run = ((mB & 'h80) == 0) && (dv <= 2);
      per = per_of(mA & 15);
      pon = (per != 0) && ((mB & 'h40) != 0) && !drst;
      hit = pon && tick_32k && (mP + 1 >= per);
      evs = (hit ? 'h40 : 0) | ((alarm_hit && !drst) ? 'h20 : 0) | ((upd_end && !drst) ? 'h10 : 0);
      rdc = rd_en && sel && (e == 'h0C);
      bw = wr_en && sel && (e == 'h0B);
      aw = wr_en && sel && (e == 'h0A);
      base = rdc ? 0 : (mC & 'h70);
      nf = base | evs;
      nb = ((wr_data & 'h80) != 0) ? (wr_data & 'hEF) : int'(wr_data);
      if (bw) irqf = ((nb & nf & 'h70) != 0);
      else irqf = (((mC & 'h80) != 0) && !rdc) || ((evs & ~base & mB & 'h70) != 0);
      uip = (mA >> 7) & 1;
      if (upd_start && run) uip = 1;
      if (upd_end || (bw && wr_data[7]) || (aw && ((wr_data >> 4) & 7) == 6)) uip = 0;
      if (wr_en && sel && !(e >= 'h0A && e <= 'h0D)) mMem[e] = wr_data;
      if (wr_en && !sel) mIdx = wr_data & 'h7F;
      mA = (uip << 7) | (aw ? (wr_data & 'h7F) : (mA & 'h7F));
      if (dev_rst) begin
        mB = mB & 'h97; mC = 0;
      end else begin
        if (bw) mB = nb;
        mC = (irqf ? 'h80 : 0) | nf;
      end
      if (!pon || hit) mP = 0;
      else if (tick_32k) mP = mP + 1;
    end
  end

  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      checks++;
      if (irq !== ((mC >> 7) & 1)) begin
        errors++;
        $display("FAIL model R5 irq actual %0b expected %0b", irq, (mC >> 7) & 1);
      end
      if (rd_en) begin
        checks++;
        if (rd_data !== 8'(m_read())) begin
          errors++;
          $display("FAIL model R2 rd_data actual %02h expected %02h", rd_data, m_read());
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk); sel = s; wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] d);
    wr(1'b0, i); wr(1'b1, d);
  endtask

  task automatic rd_port(input logic s, output int v);
    @(negedge clk); sel = s; rd_en = 1'b1;
    #2 v = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] i, output int v);
    wr(1'b0, i); rd_port(1'b1, v);
  endtask

  task automatic pulse(input int which, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      case (which)
        0: tick_32k = 1'b1;
        1: upd_start = 1'b1;
        2: upd_end = 1'b1;
        3: alarm_hit = 1'b1;
        default: dev_rst = 1'b1;
      endcase
      @(negedge clk);
      {tick_32k, upd_start, upd_end, alarm_hit, dev_rst} = '0;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8 reset values
    rd_reg(8'h0A, v); chk("R8 A", v, 'h26);
    rd_reg(8'h0B, v); chk("R8 B", v, 'h02);
    rd_reg(8'h0C, v); chk("R8 C", v, 'h00);
    rd_reg(8'h0D, v); chk("R8 D", v, 'h80);
    // R1 even read
    rd_port(1'b0, v); chk("R1 even read", v, 'hFF);
    // R2 storage and alias
    wr_reg(8'h10, 8'h5A); rd_reg(8'h10, v); chk("R2 store", v, 'h5A);
    wr_reg(8'h37, 8'h20); rd_reg(8'h32, v); chk("R2 alias write", v, 'h20);
    wr_reg(8'h32, 8'h19); rd_reg(8'hB7, v); chk("R2 alias read, index bit 7 dropped", v, 'h19);
    // R3 protected registers
    wr_reg(8'h0C, 8'hFF); rd_reg(8'h0C, v); chk("R3 C write", v, 'h00);
    wr_reg(8'h0D, 8'h00); rd_reg(8'h0D, v); chk("R3 D write", v, 'h80);
    wr_reg(8'h0A, 8'hA6); rd_reg(8'h0A, v); chk("R3 UIP not writable", v, 'h26);
    // R12 UIP set while running
    pulse(1, 1); rd_reg(8'h0A, v); chk("R12 UIP set", v, 'hA6);
    wr_reg(8'h0A, 8'h26); rd_reg(8'h0A, v); chk("R3 UIP kept", v, 'hA6);
    pulse(2, 1); rd_reg(8'h0A, v); chk("R12 UIP cleared by update end", v, 'h26);
    chk("R5 disabled flag no irq", irq, 0);
    rd_reg(8'h0C, v); chk("R5 UF only", v, 'h10);
    rd_port(1'b1, v); chk("R4 C cleared", v, 'h00);
    // R5/R4 enabled update
    wr_reg(8'h0B, 8'h12); pulse(2, 1);
    chk("R5 irq raised", irq, 1);
    rd_reg(8'h0C, v); chk("R4 C read value", v, 'h90);
    chk("R4 irq dropped", irq, 0);
    // R6 enable with pending flag
    pulse(3, 1); chk("R6 alarm flag no irq yet", irq, 0);
    wr_reg(8'h0B, 8'h22); chk("R6 irq on enable", irq, 1);
    wr_reg(8'h0B, 8'h02); chk("R6 irq off", irq, 0);
    rd_reg(8'h0C, v); chk("R6 flag kept, master cleared", v, 'h20);
    // R7 SET
    pulse(1, 1);
    wr_reg(8'h0B, 8'h92); rd_reg(8'h0B, v); chk("R7 UIE stripped", v, 'h82);
    rd_reg(8'h0A, v); chk("R7 UIP cleared", v, 'h26);
    pulse(1, 1); rd_reg(8'h0A, v); chk("R12 no UIP in SET", v, 'h26);
    wr_reg(8'h0B, 8'h02);
    // R9 periodic
    wr_reg(8'h0A, 8'h23); wr_reg(8'h0B, 8'h42);
    pulse(0, 3); chk("R9 code3 before 4 ticks", irq, 0);
    pulse(0, 1); chk("R9 code3 at 4 ticks", irq, 1);
    rd_reg(8'h0C, v); chk("R9 PF and master", v, 'hC0);
    wr_reg(8'h0A, 8'h21);
    pulse(0, 127); chk("R9 code1 before 128", irq, 0);
    pulse(0, 1); chk("R9 code1 at 128", irq, 1);
    rd_reg(8'h0C, v); chk("R9 code1 flags", v, 'hC0);
    // R10 stop
    wr_reg(8'h0A, 8'h20); pulse(0, 200);
    rd_reg(8'h0C, v); chk("R10 rate 0 stops", v, 'h00);
    wr_reg(8'h0A, 8'h23); wr_reg(8'h0B, 8'h02); pulse(0, 8);
    rd_reg(8'h0C, v); chk("R10 PIE off stops", v, 'h00);
    // R11 divider reset
    wr_reg(8'h0B, 8'h72); wr_reg(8'h0A, 8'h63);
    pulse(2, 1); pulse(3, 1); pulse(0, 8);
    chk("R11 no irq", irq, 0);
    rd_reg(8'h0C, v); chk("R11 no flags", v, 'h00);
    pulse(1, 1); rd_reg(8'h0A, v); chk("R12 no UIP in divider reset", v, 'h63);
    wr_reg(8'h0A, 8'h26);
    // R8 device reset
    wr_reg(8'h0B, 8'h7A); pulse(3, 1); chk("R8 pre irq", irq, 1);
    pulse(4, 1); chk("R8 irq cleared", irq, 0);
    rd_reg(8'h0B, v); chk("R8 B enables cleared", v, 'h12);
    rd_reg(8'h0C, v); chk("R8 C cleared", v, 'h00);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule